// File: doc/BRIEF.md
# Bidirectional universal bus transceiver register

This block joins an A bus and a B bus with one storage element per bit in each direction. For each direction the storage can pass data straight through, hold a stored word, or load a new word when its own device clock falls. The choice follows from that direction's latch enable and the level history of its device clock. Each direction also has an output enable that sets a drive flag beside the data vector. A-to-B drives when its enable is high. B-to-A drives when its enable is low.

The word is cut into independent halves. Every half has its own six controls: two output enables, two latch enables and two device clocks. The device clocks are ordinary inputs, sampled by a free-running system clock, and a falling edge is seen as "high at the previous system edge, low now". Pads and tri-state buffers sit outside the block. The surrounding logic uses the drive flags to enable them.

Top module: `ubt_xcvr`

## Requirements
- R1: While `ab_le[h]` is 1, the B output slice of half h equals the A input slice of the same half in the same cycle, with no system clock edge needed.
- R2: With `ab_le[h]` at 0, a system edge at which `ab_ck[h]` is 0 and was 1 at the previous system edge loads the current A slice into storage; from that edge on, the B output slice shows the loaded word.
- R3: With `ab_le[h]` at 0 and no falling device clock edge, the B output slice does not change, whatever the A input does.
- R4: When `ab_le[h]` drops while the device clock stays low, the B output slice keeps the A value sampled at the last system edge at which `ab_le[h]` was 1.
- R5: `b_drv[h]` is 1 exactly when `ab_oe[h]` is 1, with no system edge needed. The B data slice keeps its value when `b_drv[h]` is 0.
- R6: The B-to-A path behaves as R1 through R4 do, using `ba_le`, `ba_ck` and `b_in`. `a_drv[h]` is 1 exactly when `ba_oe_n[h]` is 0.
- R7: Half h uses data bits `[h*HALF_W +: HALF_W]` and control bit h only. Activity on one half leaves the outputs of every other half unchanged.
- R8: Reset (`rst_n` low, asynchronous) clears both storage words to zero and clears the remembered device clock level to 0. A device clock held low through reset release therefore causes no load.
- R9: If both directions of one half are enabled together, both `b_drv[h]` and `a_drv[h]` are 1. The block does not arbitrate between them.
- R10: A rising device clock edge with the latch enable at 0 loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the device clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | HALF_W*NUM_HALVES | Data seen on the A bus |
| b_in | input | HALF_W*NUM_HALVES | Data seen on the B bus |
| ab_oe | input | NUM_HALVES | A-to-B output enable per half, active high |
| ba_oe_n | input | NUM_HALVES | B-to-A output enable per half, active low |
| ab_le | input | NUM_HALVES | A-to-B latch enable per half (1 = pass through) |
| ba_le | input | NUM_HALVES | B-to-A latch enable per half |
| ab_ck | input | NUM_HALVES | A-to-B device clock per half, loads on falling edge |
| ba_ck | input | NUM_HALVES | B-to-A device clock per half |
| b_out | output | HALF_W*NUM_HALVES | Data to drive onto the B bus |
| b_drv | output | NUM_HALVES | B bus drive flag per half |
| a_out | output | HALF_W*NUM_HALVES | Data to drive onto the A bus |
| a_drv | output | NUM_HALVES | A bus drive flag per half |

## Verification
The bench builds the block with HALF_W = 8 and NUM_HALVES = 3. Eight-bit halves keep the vector table readable as hex bytes. A third half puts the active half between two idle neighbours, so a stray slice index or control index shows up on either side. The table runs both directions of the middle half through pass, load, hold, rising-edge and latch-close sequences. The neighbours stay idle and are checked for zero. Directed steps then cover changing data between system edges, both enables on at once, and reset in the middle of a run.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    // How one storage lane behaves at the coming system clock edge
    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,   // latch enable high: track the input
        MODE_CAPTURE = 2'd1,   // device clock fell: load the input
        MODE_HOLD    = 2'd2    // otherwise keep the stored word
    } lane_mode_e;

    function automatic lane_mode_e lane_mode(input logic le,
                                             input logic ck_prev,
                                             input logic ck_now);
        if (le)
            return MODE_PASS;
        else if (ck_prev && !ck_now)
            return MODE_CAPTURE;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/ubt_lane.sv
module ubt_lane #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             le,
    input  logic             ck,
    output logic [WIDTH-1:0] dout
);
    import ubt_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] store;
        logic             ck_prev;
    } lane_st_t;

    lane_st_t   st_d, st_q;
    lane_mode_e mode;

    always_comb begin
        mode       = lane_mode(le, st_q.ck_prev, ck);
        st_d       = st_q;
        st_d.ck_prev = ck;
        case (mode)
            MODE_PASS, MODE_CAPTURE: st_d.store = din;
            default:                 st_d.store = st_q.store;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // Pass-through bypass while the latch is open, stored word otherwise
    assign dout = le ? din : st_q.store;

endmodule

// File: rtl/ubt_oe_gate.sv
module ubt_oe_gate #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic en_raw,
    output logic drive
);
    generate
        if (ACTIVE_HIGH) begin : g_hi
            assign drive = en_raw;
        end else begin : g_lo
            assign drive = ~en_raw;
        end
    endgenerate
endmodule

// File: rtl/ubt_half.sv
module ubt_half #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ab_oe,
    input  logic             ba_oe_n,
    input  logic             ab_le,
    input  logic             ba_le,
    input  logic             ab_ck,
    input  logic             ba_ck,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drv,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drv
);
    ubt_lane #(.WIDTH(WIDTH)) u_ab (
        .clk (clk), .rst_n (rst_n),
        .din (a_in), .le (ab_le), .ck (ab_ck), .dout (b_out)
    );

    ubt_lane #(.WIDTH(WIDTH)) u_ba (
        .clk (clk), .rst_n (rst_n),
        .din (b_in), .le (ba_le), .ck (ba_ck), .dout (a_out)
    );

    ubt_oe_gate #(.ACTIVE_HIGH(1'b1)) u_oe_b (.en_raw (ab_oe),   .drive (b_drv));
    ubt_oe_gate #(.ACTIVE_HIGH(1'b0)) u_oe_a (.en_raw (ba_oe_n), .drive (a_drv));

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
    parameter int HALF_W     = 18,
    parameter int NUM_HALVES = 2,
    localparam int WORD_W    = HALF_W * NUM_HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic [NUM_HALVES-1:0] ab_oe,
    input  logic [NUM_HALVES-1:0] ba_oe_n,
    input  logic [NUM_HALVES-1:0] ab_le,
    input  logic [NUM_HALVES-1:0] ba_le,
    input  logic [NUM_HALVES-1:0] ab_ck,
    input  logic [NUM_HALVES-1:0] ba_ck,
    output logic [WORD_W-1:0] b_out,
    output logic [NUM_HALVES-1:0] b_drv,
    output logic [WORD_W-1:0] a_out,
    output logic [NUM_HALVES-1:0] a_drv
);
    genvar h;
    generate
        for (h = 0; h < NUM_HALVES; h++) begin : g_half
            ubt_half #(.WIDTH(HALF_W)) u_half (
                .clk     (clk),
                .rst_n   (rst_n),
                .a_in    (a_in[h*HALF_W +: HALF_W]),
                .b_in    (b_in[h*HALF_W +: HALF_W]),
                .ab_oe   (ab_oe[h]),
                .ba_oe_n (ba_oe_n[h]),
                .ab_le   (ab_le[h]),
                .ba_le   (ba_le[h]),
                .ab_ck   (ab_ck[h]),
                .ba_ck   (ba_ck[h]),
                .b_out   (b_out[h*HALF_W +: HALF_W]),
                .b_drv   (b_drv[h]),
                .a_out   (a_out[h*HALF_W +: HALF_W]),
                .a_drv   (a_drv[h])
            );
        end
    endgenerate

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int HALF_W     = 18,
    parameter int NUM_HALVES = 2,
    localparam int WORD_W    = HALF_W * NUM_HALVES
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] a_in,
    input logic [WORD_W-1:0] b_in,
    input logic [NUM_HALVES-1:0] ab_oe,
    input logic [NUM_HALVES-1:0] ba_oe_n,
    input logic [NUM_HALVES-1:0] ab_le,
    input logic [NUM_HALVES-1:0] ba_le,
    input logic [NUM_HALVES-1:0] ab_ck,
    input logic [NUM_HALVES-1:0] ba_ck,
    input logic [WORD_W-1:0] b_out,
    input logic [NUM_HALVES-1:0] b_drv,
    input logic [WORD_W-1:0] a_out,
    input logic [NUM_HALVES-1:0] a_drv
);
    // Two system edges of history since reset before $past is trusted
    logic [1:0] age_q;
    logic       live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age_q <= 2'd0;
        else if (age_q != 2'd2)
            age_q <= age_q + 2'd1;
    end
    assign live = (age_q == 2'd2);

    genvar h;
    generate
        for (h = 0; h < NUM_HALVES; h++) begin : g_chk
            p_ab_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
                ab_le[h] |-> (b_out[h*HALF_W +: HALF_W] == a_in[h*HALF_W +: HALF_W]));

            p_ab_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (live && !ab_le[h] && $past(!ab_le[h]) && $past(ab_ck[h], 2) && !$past(ab_ck[h]))
                |-> (b_out[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W])));

            p_ab_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (live && !ab_le[h] && $past(!ab_le[h]) && !($past(ab_ck[h], 2) && !$past(ab_ck[h])))
                |-> $stable(b_out[h*HALF_W +: HALF_W]));

            p_b_drv_r5: assert property (@(posedge clk) disable iff (!rst_n)
                b_drv[h] == ab_oe[h]);

            p_ba_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ba_le[h] |-> (a_out[h*HALF_W +: HALF_W] == b_in[h*HALF_W +: HALF_W]));

            p_ba_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (live && !ba_le[h] && $past(!ba_le[h]) && $past(ba_ck[h], 2) && !$past(ba_ck[h]))
                |-> (a_out[h*HALF_W +: HALF_W] == $past(b_in[h*HALF_W +: HALF_W])));

            p_ba_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (live && !ba_le[h] && $past(!ba_le[h]) && !($past(ba_ck[h], 2) && !$past(ba_ck[h])))
                |-> $stable(a_out[h*HALF_W +: HALF_W]));

            p_a_drv_r6: assert property (@(posedge clk) disable iff (!rst_n)
                a_drv[h] == !ba_oe_n[h]);
        end
    endgenerate

endmodule

bind ubt_xcvr ubt_xcvr_chk #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_chk (.*);

// File: tb/sim_ubt_xcvr.sv
`timescale 1ns/100ps
module sim_ubt_xcvr;
    localparam int HW = 8;
    localparam int NH = 3;
    localparam int WW = HW * NH;
    localparam int NV = 15;

    // {le, ck, oe, a[7:0], expected[7:0], expected drive}
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b1, 8'hA5, 8'h00, 1'b1},  // R8 cleared store
        {1'b0, 1'b1, 1'b1, 8'hA5, 8'h00, 1'b1},  // R10 rising edge
        {1'b0, 1'b0, 1'b1, 8'h3C, 8'h3C, 1'b1},  // R2 falling edge
        {1'b0, 1'b0, 1'b1, 8'hFF, 8'h3C, 1'b1},  // R3 steady low
        {1'b0, 1'b1, 1'b1, 8'h11, 8'h3C, 1'b1},  // R10 rising edge
        {1'b0, 1'b1, 1'b1, 8'h22, 8'h3C, 1'b1},  // R3 steady high
        {1'b0, 1'b0, 1'b0, 8'h77, 8'h77, 1'b0},  // R2 R5 load with drive off
        {1'b1, 1'b0, 1'b1, 8'h81, 8'h81, 1'b1},  // R1
        {1'b1, 1'b1, 1'b1, 8'h42, 8'h42, 1'b1},  // R1
        {1'b1, 1'b0, 1'b1, 8'h99, 8'h99, 1'b1},  // R1
        {1'b0, 1'b0, 1'b1, 8'h5A, 8'h99, 1'b1},  // R4 latch closes
        {1'b0, 1'b0, 1'b1, 8'hC3, 8'h99, 1'b1},  // R4
        {1'b1, 1'b0, 1'b0, 8'hE7, 8'hE7, 1'b0},  // R1 R5
        {1'b0, 1'b1, 1'b1, 8'h18, 8'hE7, 1'b1},  // R10
        {1'b0, 1'b0, 1'b1, 8'h6B, 8'h6B, 1'b1}   // R2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] a_in = '0, b_in = '0;
    logic [NH-1:0] ab_oe = '0, ba_oe_n = '1, ab_le = '0, ba_le = '0, ab_ck = '0, ba_ck = '0;
    logic [WW-1:0] b_out, a_out;
    logic [NH-1:0] b_drv, a_drv;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ubt_xcvr #(.HALF_W(HW), .NUM_HALVES(NH)) u0 (
        .clk (clk), .rst_n (rst_n), .a_in (a_in), .b_in (b_in),
        .ab_oe (ab_oe), .ba_oe_n (ba_oe_n), .ab_le (ab_le), .ba_le (ba_le),
        .ab_ck (ab_ck), .ba_ck (ba_ck), .b_out (b_out), .b_drv (b_drv),
        .a_out (a_out), .a_drv (a_drv)
    );

    function automatic logic [7:0] nswap(input logic [7:0] v);
        return {v[3:0], v[7:4]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        // reset, all controls idle
        repeat (3) @(posedge clk);
        @(negedge clk);
        a_in[0 +: HW]  = 8'h5C;  a_in[16 +: HW] = 8'h5C;
        b_in[0 +: HW]  = 8'hC5;  b_in[16 +: HW] = 8'hC5;
        ab_oe[0] = 1'b1;  ba_oe_n[2] = 1'b0;
        #0.5;
        chk("R8 reset b_out", 32'(b_out), 32'h0);
        chk("R8 reset a_out", 32'(a_out), 32'h0);
        rst_n = 1'b1;

        // table walk on half 1, both directions
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ab_le[1] = VEC[i][19]; ab_ck[1] = VEC[i][18]; ab_oe[1] = VEC[i][17];
            ba_le[1] = VEC[i][19]; ba_ck[1] = VEC[i][18]; ba_oe_n[1] = ~VEC[i][17];
            a_in[8 +: HW] = VEC[i][16:9];
            b_in[8 +: HW] = nswap(VEC[i][16:9]);
            @(posedge clk);
            #1;
            chk($sformatf("R1 R2 R3 R4 R10 vec %0d b_out", i), 32'(b_out[8 +: HW]), 32'(VEC[i][8:1]));
            chk($sformatf("R5 vec %0d b_drv", i), 32'(b_drv[1]), 32'(VEC[i][0]));
            chk($sformatf("R6 vec %0d a_out", i), 32'(a_out[8 +: HW]), 32'(nswap(VEC[i][8:1])));
            chk($sformatf("R6 vec %0d a_drv", i), 32'(a_drv[1]), 32'(VEC[i][0]));
            chk($sformatf("R7 vec %0d idle halves", i),
                32'({b_out[0 +: HW], b_out[16 +: HW], a_out[0 +: HW], a_out[16 +: HW]}), 32'h0);
            chk($sformatf("R7 vec %0d idle drives", i), 32'({b_drv[0], b_drv[2], a_drv[0], a_drv[2]}), 32'b1001);
        end

        // R1: pass-through follows A between system edges
        @(negedge clk);
        ab_le[1] = 1'b1;  a_in[8 +: HW] = 8'h3E;
        #0.5;
        chk("R1 comb first", 32'(b_out[8 +: HW]), 32'h3E);
        a_in[8 +: HW] = 8'hD4;
        #0.5;
        chk("R1 comb second", 32'(b_out[8 +: HW]), 32'hD4);

        // R9: both directions of half 0 enabled
        ba_oe_n[0] = 1'b0;
        #0.5;
        chk("R9 both drives", 32'({b_drv[0], a_drv[0]}), 32'b11);
        if (b_drv[0] && a_drv[0])
            $display("NOTE bus contention flagged on half 0");
        ba_oe_n[0] = 1'b1;

        // R7: load half 0 with a falling edge while half 2 stays idle
        @(negedge clk);
        ab_le[1] = 1'b0;  ab_ck[0] = 1'b1;
        @(negedge clk);
        ab_ck[0] = 1'b0;  a_in[0 +: HW] = 8'h9A;  a_in[16 +: HW] = 8'h12;
        @(posedge clk);
        #1;
        chk("R7 half 0 loaded", 32'(b_out[0 +: HW]), 32'h9A);
        chk("R7 half 2 untouched", 32'(b_out[16 +: HW]), 32'h0);
        chk("R3 half 1 held", 32'(b_out[8 +: HW]), 32'hD4);

        // R8: reset mid-run, device clocks held low through release
        @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        chk("R8 mid-run reset clears", 32'(b_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        a_in[8 +: HW] = 8'h77;
        @(posedge clk);
        #1;
        chk("R8 no load after release", 32'(b_out[8 +: HW]), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule